// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives a two-wire management bus (MDC clock, bidirectional MDIO data) and is controlled through two 32-bit registers. The settings register holds the MDC divisor, a preamble enable and a read-only completion flag. The frame register holds a complete 32-bit management frame image. Software writes that image with the start bit set, and the block shifts it out on MDIO, most significant bit first. For a read it releases the line at the turnaround and shifts in the PHY's 16 reply bits. When the last bit time ends the completion flag rises, and after a read the reply appears in the low half of the frame register.

The register fields sit at fixed positions, so software builds a frame by OR-ing fields together. Bit 30 is the start marker, bit 29 asks for a read, bit 28 asks for a write, the register address field begins at bit 18 and the turnaround pattern sits at bits 17:16. Some PHYs need a select step first. For these, software writes a PHY-select frame: a plain write to register 0x1F that carries the PHY number at bits 8:4 of the data field. It then writes the real frame once the flag is set.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset both registers read as zero, MDC is low and MDIO is not driven (mdio_oe low).
- R2: In the settings register, bits 6:0 hold the divisor and bit 7 enables the preamble. Bit 8 is the completion flag, which reads back but cannot be written. Writing 0 clears the divisor and the preamble enable and leaves the flag as it was.
- R3: A frame-register write with bit 30 set, accepted while idle, starts a transaction and clears the completion flag in the same cycle. A write with bit 30 clear is stored but starts nothing.
- R4: A frame-register write that arrives during a transaction is ignored. The register keeps its contents and the transaction on the wire is unchanged.
- R5: While a transaction runs, one MDC period lasts 2 x (divisor + 1) system clocks. MDC is low when idle.
- R6: With the preamble enabled, 32 ones go out before the 32 frame bits. Without it only the 32 frame bits go out. Frame bits are sent from bit 31 down to bit 0.
- R7: MDIO and its enable change only when MDC falls or a transaction starts. They are stable while MDC is high.
- R8: When bit 29 is set (read), the master stops driving MDIO for frame bits 17 down to 0 (18 bit times) and samples the 16 reply bits on rising MDC edges. When bit 29 is clear, the master drives every bit.
- R9: After a read, bits 15:0 of the frame register hold the reply, first-received bit as bit 15, and bits 31:16 are unchanged. After a write the register keeps the written image.
- R10: The completion flag rises as the final bit time ends. A PHY-select frame (register 0x1F in bits 22:18, PHY number in bits 8:4) behaves as an ordinary write frame and may be followed at once by another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 settings, 1 frame |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 settings, 1 frame |
| rd_data | output | 32 | Read data for the register selected by rd_sel |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (low releases the line) |
| mdio_i | input | 1 | MDIO input value |

## Verification
Frames are tried as writes and reads, with and without preamble, at divisors 0, 1, 2 and 5. Each case compares the whole line history, the count of released bit times and the measured MDC period against values derived from the frame image. This separates errors in bit order, in preamble length, in the turnaround window and in the clock division. A PHY-select write followed straight away by a read shows that back-to-back frames are handled. Directed cases cover a frame write during a busy transaction, a write without the start bit, and writes to the read-only flag bit.

// File: rtl/mdio_eng_pkg.sv
// Package: shared register geometry for the MDIO frame master.
// Assumes a 32-bit register file and the fixed frame bit positions below.
package mdio_eng_pkg;
    localparam int REG_W       = 32;
    localparam int FRAME_BITS  = REG_W;
    localparam int DATA_BITS   = 16;
    localparam int CTRL_DIV_W  = 7;
    localparam int CTRL_PRE    = 7;
    localparam int CTRL_DONE   = 8;
    localparam int FR_START    = 30;
    localparam int FR_READ     = 29;
    localparam int FR_TA_HI    = 17;
endpackage

// File: rtl/mdio_clk_div.sv
// Module: MDC generator. Counts system clocks up to the divisor, toggles MDC
// and flags the rising and falling half-period boundaries.
// Assumes: div_i stays stable while run_i is high; MDC parks low when idle.
module mdio_clk_div
    import mdio_eng_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic [CTRL_DIV_W-1:0] div_i,
    output logic                  mdc_o,
    output logic                  rise_o,
    output logic                  fall_o
);
    logic [CTRL_DIV_W-1:0] cnt_q;
    logic                  mdc_q;
    logic                  tick;

    assign tick   = run_i && (cnt_q == div_i);
    assign rise_o = tick && !mdc_q;
    assign fall_o = tick && mdc_q;
    assign mdc_o  = mdc_q;

    // Half-period counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_mdc_low_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !mdc_q);
endmodule

// File: rtl/mdio_serializer.sv
// Module: frame shifter. Loads a frame image on start, sends an optional
// preamble of ones and then the image MSB first, changing MDIO on falling
// MDC. For reads it releases MDIO from the turnaround onward and captures
// the reply on rising MDC.
// Assumes: rise_i/fall_i come from mdio_clk_div running while busy_o is high.
module mdio_serializer
    import mdio_eng_pkg::*;
#(
    parameter int PRE_BITS = 32
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  pre_i,
    input  logic                  rise_i,
    input  logic                  fall_i,
    input  logic                  mdio_i,
    output logic                  busy_o,
    output logic                  finish_o,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic [DATA_BITS-1:0]  rdata_o
);
    localparam int TOT   = PRE_BITS + FRAME_BITS;
    localparam int POS_W = $clog2(TOT);
    localparam int IDX_W = $clog2(FRAME_BITS);

    logic                  busy_q, rd_q, line_q, oe_q;
    logic [POS_W-1:0]      pos_q, nxt_pos, start_pos;
    logic [FRAME_BITS-1:0] img_q;
    logic [DATA_BITS-1:0]  shift_q;
    logic                  first_bit, next_bit;

    assign nxt_pos = pos_q - 1'b1;

    generate
        if (PRE_BITS > 0) begin : g_pre
            // Positions at or above FRAME_BITS belong to the preamble.
            assign start_pos = pre_i ? POS_W'(TOT - 1) : POS_W'(FRAME_BITS - 1);
            assign first_bit = pre_i ? 1'b1 : frame_i[FRAME_BITS-1];
            assign next_bit  = (nxt_pos >= POS_W'(FRAME_BITS)) ? 1'b1
                             : img_q[nxt_pos[IDX_W-1:0]];
        end else begin : g_nopre
            assign start_pos = POS_W'(FRAME_BITS - 1);
            assign first_bit = frame_i[FRAME_BITS-1];
            assign next_bit  = img_q[nxt_pos[IDX_W-1:0]];
        end
    endgenerate

    // Sequencing of bit positions, line drive, release and reply capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            rd_q    <= 1'b0;
            line_q  <= 1'b0;
            oe_q    <= 1'b0;
            pos_q   <= '0;
            img_q   <= '0;
            shift_q <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            pos_q  <= start_pos;
            rd_q   <= frame_i[FR_READ];
            img_q  <= frame_i;
            line_q <= first_bit;
            oe_q   <= 1'b1;
        end else if (busy_q) begin
            if (rise_i && rd_q && (pos_q < POS_W'(DATA_BITS)))
                shift_q <= {shift_q[DATA_BITS-2:0], mdio_i};
            if (fall_i) begin
                if (pos_q == '0) begin
                    busy_q <= 1'b0;
                    oe_q   <= 1'b0;
                    line_q <= 1'b0;
                end else begin
                    pos_q  <= nxt_pos;
                    line_q <= next_bit;
                    oe_q   <= !(rd_q && (nxt_pos <= POS_W'(FR_TA_HI)));
                end
            end
        end
    end

    assign busy_o   = busy_q;
    assign finish_o = busy_q && fall_i && (pos_q == '0);
    assign mdio_o   = line_q;
    assign mdio_oe  = oe_q;
    assign rdata_o  = shift_q;

    p_capture_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && rise_i && rd_q && (pos_q < POS_W'(DATA_BITS))) |-> !oe_q);
endmodule

// File: rtl/mdio_frame_engine.sv
// Module: register-mapped MDIO frame master (top). Decodes the settings and
// frame registers, latches the divisor at frame start, and keeps the
// completion flag and the reply write-back.
// Assumes: one register write per cycle; reads are combinational.
module mdio_frame_engine
    import mdio_eng_pkg::*;
#(
    parameter int PRE_BITS = 32
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic [CTRL_DIV_W-1:0] div_q, run_div_q;
    logic                  pre_q, done_q;
    logic [REG_W-1:0]      frame_q;
    logic                  busy, finish, rise, fall, fr_wr, accept;
    logic [DATA_BITS-1:0]  rdata;

    assign fr_wr  = wr_en && wr_sel && !busy;
    assign accept = fr_wr && wr_data[FR_START];

    // Settings register: divisor and preamble enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            pre_q <= 1'b0;
        end else if (wr_en && !wr_sel) begin
            div_q <= wr_data[CTRL_DIV_W-1:0];
            pre_q <= wr_data[CTRL_PRE];
        end
    end

    // Frame register, divisor snapshot and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q   <= '0;
            run_div_q <= '0;
            done_q    <= 1'b0;
        end else begin
            if (fr_wr)
                frame_q <= wr_data;
            else if (finish && frame_q[FR_READ])
                frame_q[DATA_BITS-1:0] <= rdata;
            if (accept) begin
                run_div_q <= div_q;
                done_q    <= 1'b0;
            end else if (finish) begin
                done_q <= 1'b1;
            end
        end
    end

    // Register read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data = frame_q;
        end else begin
            rd_data[CTRL_DIV_W-1:0] = div_q;
            rd_data[CTRL_PRE]       = pre_q;
            rd_data[CTRL_DONE]      = done_q;
        end
    end

    mdio_clk_div u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .div_i  (run_div_q),
        .mdc_o  (mdc),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_serializer #(.PRE_BITS(PRE_BITS)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept),
        .frame_i  (wr_data),
        .pre_i    (pre_q),
        .rise_i   (rise),
        .fall_i   (fall),
        .mdio_i   (mdio_i),
        .busy_o   (busy),
        .finish_o (finish),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rdata_o  (rdata)
    );

    p_start_clears_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done_q);
    p_busy_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_sel && !finish) |=> $stable(frame_q));
    p_line_stable_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
    p_done_means_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy);
endmodule

// File: tb/mdio_frame_engine_bench.sv
module mdio_frame_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int nchk = 0, nfail = 0;

    always #2 clk = ~clk;

    mdio_frame_engine u_mdio_frame_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: records the line on rising MDC and replies during the data phase.
    logic [63:0] hist;
    int          rise_cnt, rel_cnt, nb;
    longint      t_r0, t_r1;
    logic [15:0] rdval;
    logic        hist_clr = 1'b0;

    function automatic logic reply_bit(int k, int n, logic [15:0] v);
        if (k >= n - 16 && k < n) return v[n - 1 - k];
        return 1'b1;
    endfunction

    assign mdio_i = reply_bit(rise_cnt, nb, rdval);

    always @(posedge mdc or posedge hist_clr) begin
        if (hist_clr) begin
            hist <= '0; rise_cnt <= 0; rel_cnt <= 0; t_r0 <= 0; t_r1 <= 0;
        end else begin
            hist <= {hist[62:0], mdio_oe ? mdio_o : mdio_i};
            if (!mdio_oe) rel_cnt <= rel_cnt + 1;
            if (rise_cnt == 0) t_r0 <= $time;
            if (rise_cnt == 1) t_r1 <= $time;
            rise_cnt <= rise_cnt + 1;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(logic s, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic s, output logic [31:0] d);
        rd_sel = s; #1; d = rd_data;
    endtask

    task automatic clear_model();
        hist_clr = 1'b1; #1; hist_clr = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] c;
        bit ok = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            reg_rd(1'b0, c);
            if (c[8]) begin ok = 1; break; end
        end
        if (!ok) chk("R10 completion timeout", 64'd0, 64'd1);
    endtask

    localparam int NV = 5;
    localparam logic [31:0] V_CTRL  [NV] = '{32'h82, 32'h02, 32'h80, 32'h05, 32'h01};
    localparam logic [31:0] V_FRAME [NV] = '{32'h518A_ABCD, 32'h60C6_0000,
                                             32'h6FFE_0000, 32'h507E_0050, 32'h600A_0000};
    localparam logic [15:0] V_REPLY [NV] = '{16'h0000, 16'h3C5A, 16'h8001, 16'h0000, 16'hB6D2};

    initial begin
        #(4 * 200000);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] a_img;
        nb = 32; rdval = '0;
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        reg_rd(1'b0, r); chk("R1 settings after reset", 64'(r), 64'h0);
        reg_rd(1'b1, r); chk("R1 frame after reset", 64'(r), 64'h0);
        chk("R1 mdc low", 64'(mdc), 64'h0);
        chk("R1 mdio released", 64'(mdio_oe), 64'h0);

        // Table of frames
        for (int v = 0; v < NV; v++) begin
            logic [31:0] f, c;
            logic [63:0] exp_line;
            logic [31:0] e32;
            logic        rd, pre;
            int          dv;
            c = V_CTRL[v]; f = V_FRAME[v];
            rd = f[29]; pre = c[7]; dv = int'(c[6:0]);
            reg_wr(1'b0, c);
            nb = pre ? 64 : 32; rdval = V_REPLY[v];
            clear_model();
            reg_wr(1'b1, f);
            reg_rd(1'b0, r); chk("R3 flag cleared on start", 64'(r[8]), 64'h0);
            wait_done();
            e32 = rd ? {f[31:18], 2'b11, V_REPLY[v]} : f;
            exp_line = pre ? {32'hFFFF_FFFF, e32} : {32'h0, e32};
            chk("R6 R7 line bits", hist, exp_line);
            chk("R6 bit count", 64'(rise_cnt), 64'(nb));
            chk("R8 released bit times", 64'(rel_cnt), rd ? 64'd18 : 64'd0);
            chk("R5 mdc period ns", 64'(t_r1 - t_r0), 64'(8 * (dv + 1)));
            reg_rd(1'b1, r);
            chk("R9 frame readback", 64'(r), 64'(rd ? {f[31:16], V_REPLY[v]} : f));
            reg_rd(1'b0, r);
            chk("R10 R2 settings with flag", 64'(r), 64'(32'h100 | (c & 32'hFF)));
        end

        // R4: frame write during a transaction is ignored
        a_img = 32'h5123_4567;
        reg_wr(1'b0, 32'h01);
        nb = 32; rdval = '0;
        clear_model();
        reg_wr(1'b1, a_img);
        repeat (20) @(negedge clk);
        reg_wr(1'b1, 32'h6FFF_FFFF);
        reg_rd(1'b1, r); chk("R4 register kept while busy", 64'(r), 64'(a_img));
        wait_done();
        chk("R4 wire frame unchanged", hist, {32'h0, a_img});
        chk("R4 no release on write", 64'(rel_cnt), 64'd0);

        // R3: write without start bit starts nothing
        clear_model();
        reg_wr(1'b1, 32'h1000_0000);
        repeat (40) @(negedge clk);
        chk("R3 no MDC activity", 64'(rise_cnt), 64'd0);
        reg_rd(1'b0, r); chk("R3 flag kept", 64'(r[8]), 64'h1);
        reg_rd(1'b1, r); chk("R3 image stored", 64'(r), 64'h1000_0000);

        // R2: flag is read-only; writing 0 clears settings only
        reg_wr(1'b0, 32'hFFFF_FFFF);
        reg_rd(1'b0, r); chk("R2 all-ones write", 64'(r), 64'h1FF);
        reg_wr(1'b0, 32'h0);
        reg_rd(1'b0, r); chk("R2 zero write", 64'(r), 64'h100);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule